// File: doc/BRIEF.md
# Sliding-Window Zero-Count Detector

This block examines a serial bit stream that arrives one bit per clock. A qualifier marks each cycle that carries a real bit. On every qualified cycle the block looks at a three-bit window: the current bit and the two qualified bits before it. It raises its output in the same cycle when that window holds the selected number of zeros, which is two by default. The output is combinational from the stored state and the incoming bit, so it belongs to the bit being consumed (Mealy style).

Three start-up states cover the period after reset, before two bits of history exist, so the output never asserts on a partial window. After that, four steady states each record the last two bits. A cycle without a qualified bit keeps the state through a feedback path, not a gated clock, and forces the output low. A parameter picks the state encoding: an adjacency-minded assignment, or plain binary. The one 3-bit code that is not used sends the machine back to the start state on the next clock.

Top module: `zero_window_detector`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `y` is 0. After the first clock edge with `rst` high the machine is in its start state, so `y` is 0 on the first qualified bit after reset.
- R2: On the first and second qualified bits after reset, `y` is 0 whatever their values.
- R3: From the third qualified bit on, `y` is 1 exactly when the window {older bit, previous bit, current `x`} holds ZERO_TARGET zeros. The windows are evaluated with overlap, one per qualified bit. With the default of 2, the windows 001, 010 and 100 (oldest bit first) give `y` = 1.
- R4: With the default ZERO_TARGET, the windows 000, 011, 101, 110 and 111 give `y` = 0.
- R5: In a cycle with `x_valid` low, `y` is 0 and the stored history is kept. The next qualified bit is judged against the same two earlier bits it would have seen with no gap.
- R6: A reset in the middle of a stream discards the history, and the two-bit warm-up of R2 starts again.
- R7: ENCODING = 0 uses these codes: start 000, first-bit-0 010, first-bit-1 011, history 11 → 111, 01 → 101, 10 → 110, 00 → 100. ENCODING = 1 numbers the same seven states 0 to 6 in that order. Both encodings give the same port behaviour. The unused code moves to the start state on the next clock.
- R8: ZERO_TARGET (0 to 3) selects the zero count that R3 matches. Values outside that range are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit |
| x_valid | input | 1 | High when `x` carries a bit to consume |
| y | output | 1 | Window match for the bit consumed this cycle |

## Verification
The bench builds three copies of the block. The first uses the adjacency encoding with a target of two zeros, the second the binary encoding with the same target, and the third the adjacency encoding with a target of one zero. Every 8-bit stream is driven into all three, once fully qualified and once under sixteen gap patterns. Every stream is also cut by a reset after its fifth bit. This covers every window value reached from every warm-up path, qualifier gaps at every position, and restarts from each steady state. Comparing the two encodings on the same streams shows that the choice of codes does not change what reaches the port.

// File: rtl/zwd_pkg.sv
package zwd_pkg;

   // Abstract machine states, in the order used by the binary encoding
   typedef enum logic [2:0] {
      ST_START  = 3'd0,
      ST_FIRST0 = 3'd1,
      ST_FIRST1 = 3'd2,
      ST_H11    = 3'd3,
      ST_H01    = 3'd4,
      ST_H10    = 3'd5,
      ST_H00    = 3'd6
   } zwd_state_e;

   localparam int ENC_ADJACENT = 0;
   localparam int ENC_BINARY   = 1;
   localparam int CODE_W       = 3;

   // Adjacency-minded codes: bit2 = steady phase, bit0 = newest bit seen
   function automatic logic [CODE_W-1:0] code_adjacent(zwd_state_e s);
      case (s)
         ST_START:  return 3'b000;
         ST_FIRST0: return 3'b010;
         ST_FIRST1: return 3'b011;
         ST_H11:    return 3'b111;
         ST_H01:    return 3'b101;
         ST_H10:    return 3'b110;
         default:   return 3'b100;
      endcase
   endfunction

   function automatic logic [CODE_W-1:0] code_binary(zwd_state_e s);
      return CODE_W'(s);
   endfunction

   function automatic logic [CODE_W-1:0] code_of(int style, zwd_state_e s);
      return (style == ENC_ADJACENT) ? code_adjacent(s) : code_binary(s);
   endfunction

   function automatic logic is_steady(zwd_state_e s);
      return (s == ST_H11) || (s == ST_H01) || (s == ST_H10) || (s == ST_H00);
   endfunction

   function automatic logic newest_bit(zwd_state_e s);
      return (s == ST_FIRST1) || (s == ST_H11) || (s == ST_H01);
   endfunction

   function automatic logic older_bit(zwd_state_e s);
      return (s == ST_H11) || (s == ST_H10);
   endfunction

endpackage

// File: rtl/zwd_decoder.sv
module zwd_decoder
   import zwd_pkg::*;
#(
   parameter int ENCODING = ENC_ADJACENT,
   parameter int STATE_W  = CODE_W
) (
   input  logic [STATE_W-1:0] code,
   output zwd_state_e         state,
   output logic               legal
);

   generate
      if (ENCODING == ENC_ADJACENT) begin : g_adj
         always_comb begin
            legal = 1'b1;
            state = ST_START;
            case (code)
               3'b000:  state = ST_START;
               3'b010:  state = ST_FIRST0;
               3'b011:  state = ST_FIRST1;
               3'b111:  state = ST_H11;
               3'b101:  state = ST_H01;
               3'b110:  state = ST_H10;
               3'b100:  state = ST_H00;
               default: legal = 1'b0;
            endcase
         end
      end else begin : g_bin
         always_comb begin
            legal = (code <= STATE_W'(ST_H00));
            state = legal ? zwd_state_e'(code) : ST_START;
         end
      end
   endgenerate

endmodule

// File: rtl/zwd_encoder.sv
module zwd_encoder
   import zwd_pkg::*;
#(
   parameter int ENCODING = ENC_ADJACENT,
   parameter int STATE_W  = CODE_W
) (
   input  zwd_state_e         state,
   output logic [STATE_W-1:0] code
);

   generate
      if (ENCODING == ENC_ADJACENT) begin : g_adj
         always_comb code = code_adjacent(state);
      end else begin : g_bin
         always_comb code = code_binary(state);
      end
   endgenerate

endmodule

// File: rtl/zwd_next.sv
module zwd_next
   import zwd_pkg::*;
(
   input  zwd_state_e cur,
   input  logic       legal,
   input  logic       x,
   input  logic       x_valid,
   output zwd_state_e nxt
);

   always_comb begin
      nxt = cur;
      if (!legal) begin
         nxt = ST_START;
      end else if (x_valid) begin
         case (cur)
            ST_START:          nxt = x ? ST_FIRST1 : ST_FIRST0;
            ST_FIRST0:         nxt = x ? ST_H01    : ST_H00;
            ST_FIRST1:         nxt = x ? ST_H11    : ST_H10;
            ST_H11, ST_H01:    nxt = x ? ST_H11    : ST_H10;
            default:           nxt = x ? ST_H01    : ST_H00;
         endcase
      end
   end

endmodule

// File: rtl/zwd_out.sv
module zwd_out
   import zwd_pkg::*;
#(
   parameter int ZERO_TARGET = 2
) (
   input  zwd_state_e cur,
   input  logic       rst,
   input  logic       x,
   input  logic       x_valid,
   output logic       y
);

   localparam int WIN = 3;

   logic [WIN-1:0] window;
   logic [1:0]     zeros;

   always_comb begin
      window = {older_bit(cur), newest_bit(cur), x};
      zeros  = 2'(WIN - $countones(window));
      y      = !rst && x_valid && is_steady(cur) && (zeros == 2'(ZERO_TARGET));
   end

endmodule

// File: rtl/zero_window_detector.sv
module zero_window_detector
   import zwd_pkg::*;
#(
   parameter int ENCODING    = ENC_ADJACENT,
   parameter int STATE_W     = 3,
   parameter int ZERO_TARGET = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic x,
   input  logic x_valid,
   output logic y
);

   localparam logic [STATE_W-1:0] START_CODE = code_of(ENCODING, ST_START);

   generate
      if (STATE_W != CODE_W) begin : g_bad_width
         $error("zero_window_detector: STATE_W must be 3");
      end
      if (ZERO_TARGET < 0 || ZERO_TARGET > 3) begin : g_bad_target
         $error("zero_window_detector: ZERO_TARGET must lie in 0..3");
      end
      if (ENCODING != ENC_ADJACENT && ENCODING != ENC_BINARY) begin : g_bad_enc
         $error("zero_window_detector: unknown ENCODING");
      end
   endgenerate

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;
   zwd_state_e         cur_state;
   zwd_state_e         nxt_state;
   logic               code_legal;

   zwd_decoder #(.ENCODING(ENCODING), .STATE_W(STATE_W)) u_dec (
      .code  (state_q),
      .state (cur_state),
      .legal (code_legal)
   );

   zwd_next u_next (
      .cur     (cur_state),
      .legal   (code_legal),
      .x       (x),
      .x_valid (x_valid),
      .nxt     (nxt_state)
   );

   zwd_encoder #(.ENCODING(ENCODING), .STATE_W(STATE_W)) u_enc (
      .state (nxt_state),
      .code  (state_d)
   );

   zwd_out #(.ZERO_TARGET(ZERO_TARGET)) u_out (
      .cur     (cur_state),
      .rst     (rst),
      .x       (x),
      .x_valid (x_valid),
      .y       (y)
   );

   // State register: hold is a mux path in the next-state logic, clock is free-running
   always_ff @(posedge clk) begin
      if (rst) state_q <= START_CODE;
      else     state_q <= state_d;
   end

   assert_reset_start_R1: assert property (@(posedge clk)
      rst |=> (state_q == START_CODE));

   assert_no_early_match_R2: assert property (@(posedge clk) disable iff (rst)
      y |-> is_steady(cur_state));

   assert_window_shift_R3: assert property (@(posedge clk) disable iff (rst)
      (x_valid && code_legal && cur_state != ST_START) |=> (newest_bit(cur_state) == $past(x)));

   assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      !x_valid |-> !y);

   assert_gap_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!x_valid && code_legal) |=> $stable(state_q));

   assert_unused_recover_R7: assert property (@(posedge clk) disable iff (rst)
      !code_legal |=> (state_q == START_CODE));

endmodule

// File: tb/zero_window_detector_tb.sv
module zero_window_detector_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic x = 1'b0;
   logic x_valid = 1'b0;
   logic y_adj, y_bin, y_t1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference history: two most recent qualified bits and a saturating count
   logic [1:0] hist = 2'b00;
   int         seen = 0;
   bit         midreset = 0;

   always #10 clk = ~clk;

   zero_window_detector #(.ENCODING(0), .ZERO_TARGET(2)) u_dut (
      .clk(clk), .rst(rst), .x(x), .x_valid(x_valid), .y(y_adj));

   zero_window_detector #(.ENCODING(1), .ZERO_TARGET(2)) u_dut_bin (
      .clk(clk), .rst(rst), .x(x), .x_valid(x_valid), .y(y_bin));

   zero_window_detector #(.ENCODING(0), .ZERO_TARGET(1)) u_dut_t1 (
      .clk(clk), .rst(rst), .x(x), .x_valid(x_valid), .y(y_t1));

   task automatic chk(string tag, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   function automatic logic expect_y(int target, logic xb, logic vb, logic rb);
      int zeros;
      zeros = 3 - ($countones(hist) + int'(xb));
      return !rb && vb && (seen >= 2) && (zeros == target);
   endfunction

   task automatic step(logic xb, logic vb, logic rb);
      logic e2, e1;
      string tag;
      @(negedge clk);
      x = xb; x_valid = vb; rst = rb;
      #5;
      e2 = expect_y(2, xb, vb, rb);
      e1 = expect_y(1, xb, vb, rb);
      if (rb)            tag = "R1";
      else if (!vb)      tag = "R5";
      else if (seen < 2) tag = midreset ? "R6" : "R2";
      else if (e2)       tag = "R3";
      else               tag = "R4";
      chk(tag, y_adj, e2);
      chk({"R7 ", tag}, y_bin, e2);
      chk({"R8 ", tag}, y_t1, e1);
      @(posedge clk);
      #1;
      if (rb) begin
         hist = 2'b00; seen = 0;
      end else if (vb) begin
         hist = {hist[0], xb};
         if (seen < 2) seen++;
      end
   endtask

   task automatic do_reset();
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1);
   endtask

   initial begin
      #(20 * 190000);
      n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // reset state, checked on the first qualified bit (R1)
      do_reset();
      step(1'b0, 1'b1, 1'b0);

      // every 8-bit stream, all bits qualified: R2, R3, R4 with overlapping windows
      for (int s = 0; s < 256; s++) begin
         do_reset();
         for (int i = 7; i >= 0; i--) step(s[i], 1'b1, 1'b0);
      end

      // same streams under qualifier gaps (R5)
      for (int s = 0; s < 256; s++) begin
         for (int m = 0; m < 16; m++) begin
            logic [7:0] vm;
            vm = {m[3:0], m[3:0] ^ 4'b1010};
            do_reset();
            for (int i = 7; i >= 0; i--) begin
               if (!vm[i]) step(~s[i], 1'b0, 1'b0);
               step(s[i], 1'b1, 1'b0);
            end
         end
      end

      // reset in mid-stream after five bits (R6)
      for (int s = 0; s < 256; s++) begin
         midreset = 0;
         do_reset();
         for (int i = 7; i >= 3; i--) step(s[i], 1'b1, 1'b0);
         midreset = 1;
         step(s[0], 1'b1, 1'b1);
         for (int i = 4; i >= 0; i--) step(s[i] ^ s[7], 1'b1, 1'b0);
         midreset = 0;
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule